// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns an arbitrary system clock into a stream of single-cycle tick strobes. These serve as the 16x oversampling reference of an asynchronous serial port, or as a fixed pulse-reference clock for an infrared link. The tick period is programmable with an integer divisor and a sixteenth-step fraction. A four-bit phase accumulator spreads the fractional clocks over the ticks, so the average period need not be a whole number of clocks.

The divisor port holds the wanted period minus one. The fraction comes from an eight-bit correction word, of which only the upper nibble is used. Both values are captured when a tick period completes, so a period that is under way is never shortened or lengthened by a write. A parameter selects the narrow infrared variant, in which a divisor of zero is rejected: the block then holds off all ticks and raises an error flag. Dropping the enable clears the counter and the accumulator, and the next enable starts from a clean phase.

Top module: `baud_tick_gen`

## Requirements
- R1: After a synchronous reset, `tick_o` and `err_o` are low.
- R2: While `en_i` is low, `tick_o` and `err_o` stay low. Re-enabling restarts the phase: the first tick again follows a full fresh period, and no fractional stretch is carried over from before.
- R3: With divisor value N, the first tick appears N+1 enabled clock edges after the first edge with `en_i` high.
- R4: Each later period is N+1 clocks, plus one clock when the previous tick carried out of the four-bit accumulator. At every tick the accumulator adds the fraction of the period that just ended.
- R5: Over any 16 consecutive periods that follow the first tick, the total length is exactly 16*(N+1)+F clocks, where F is the fraction.
- R6: With fraction zero, every period is exactly N+1 clocks.
- R7: New divisor and fraction values are captured only at a tick. The period that is running when the ports change completes with the old values, and the new values govern the period after the next tick.
- R8: The fraction is taken from bits [7:4] of `corr_i`. Bits [3:0] have no effect on the tick timing.
- R9: In the zero-illegal variant (`ZERO_IS_ILLEGAL`=1), a divisor of zero while enabled yields no ticks and holds `err_o` high. Writing a nonzero divisor then clears `err_o` after one edge, and the first tick follows N+1 edges after that.
- R10: In the default variant, a divisor of zero is legal and gives periods of one clock, or two clocks when a carry occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run enable; low clears counter and accumulator |
| div_i | input | DIV_W | Integer divisor minus one |
| corr_i | input | 8 | Correction word; fraction in bits [7:4] |
| tick_o | output | 1 | Single-cycle tick strobe (registered) |
| err_o | output | 1 | Illegal divisor flag (registered) |

## Verification
Two events can land on the same clock edge: a tick that closes a period, and the capture of new register values together with the accumulator carry that sets the length of the next period. The bench provokes this by changing the divisor and fraction on the falling edge right after a tick, so that the change is pending when the next tick comes. It then measures each interval between ticks against a model in which old values finish their period and new ones start only after that tick. A second collision, an enable drop directly after a tick, is judged by requiring the restarted stream to show no carried-over stretch.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;
  localparam int FRAC_W   = 4;
  localparam int CORR_W   = 8;
  localparam int FRAC_LSB = 4;
  typedef logic [FRAC_W-1:0] frac_t;
endpackage

// File: rtl/baud_cfg_hold.sv
module baud_cfg_hold
  import baud_tick_pkg::*;
#(
  parameter int DIV_W           = 12,
  parameter bit ZERO_IS_ILLEGAL = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              run_i,
  input  logic              load_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [CORR_W-1:0] corr_i,
  output logic [DIV_W-1:0]  div_q_o,
  output frac_t             frac_q_o,
  output logic              bad_o
);
  logic take;
  logic unused_low;

  // capture while idle, at a period boundary, or while an illegal value is held
  assign take       = !run_i || load_i || bad_o;
  assign unused_low = ^corr_i[FRAC_LSB-1:0];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      div_q_o  <= '0;
      frac_q_o <= '0;
    end else if (take) begin
      div_q_o  <= div_i;
      frac_q_o <= corr_i[FRAC_LSB +: FRAC_W];
    end
  end

  generate
    if (ZERO_IS_ILLEGAL) begin : g_zero_bad
      assign bad_o = (div_q_o == '0);
    end else begin : g_zero_ok
      assign bad_o = 1'b0;
    end
  endgenerate

  AST_CFG_HELD_MIDPERIOD: assert property (@(posedge clk_i) disable iff (rst_i)
    (run_i && !load_i && !bad_o) |=> ($stable(div_q_o) && $stable(frac_q_o))); // R7
endmodule

// File: rtl/baud_frac_acc.sv
module baud_frac_acc
  import baud_tick_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_i,
  input  logic  clear_i,
  input  logic  step_i,
  input  frac_t frac_i,
  output logic  stretch_o
);
  frac_t             acc_q;
  logic [FRAC_W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, frac_i};

  always_ff @(posedge clk_i) begin
    if (rst_i || clear_i) begin
      acc_q     <= '0;
      stretch_o <= 1'b0;
    end else if (step_i) begin
      acc_q     <= sum[FRAC_W-1:0];
      stretch_o <= sum[FRAC_W];
    end
  end

  AST_STRETCH_ONLY_AT_TICK: assert property (@(posedge clk_i) disable iff (rst_i)
    (!step_i && !clear_i) |=> $stable(stretch_o)); // R4
endmodule

// File: rtl/baud_period_cnt.sv
module baud_period_cnt #(
  parameter int DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             clear_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             stretch_i,
  output logic             wrap_o
);
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit  = {1'b0, div_i} + {{DIV_W{1'b0}}, stretch_i};
  assign wrap_o = !clear_i && (cnt_q == limit);

  always_ff @(posedge clk_i) begin
    if (rst_i || clear_i) begin
      cnt_q <= '0;
    end else if (wrap_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_CNT_WITHIN_LIMIT: assert property (@(posedge clk_i) disable iff (rst_i)
    !clear_i |-> (cnt_q <= limit)); // R4
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_tick_pkg::*;
#(
  parameter int DIV_W           = 12,
  parameter bit ZERO_IS_ILLEGAL = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              en_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [CORR_W-1:0] corr_i,
  output logic              tick_o,
  output logic              err_o
);
  logic [DIV_W-1:0] div_q;
  frac_t            frac_q;
  logic             bad;
  logic             wrap;
  logic             stretch;
  logic             halt;

  assign halt = !en_i || bad;

  baud_cfg_hold #(
    .DIV_W          (DIV_W),
    .ZERO_IS_ILLEGAL(ZERO_IS_ILLEGAL)
  ) cfg_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .run_i   (en_i),
    .load_i  (wrap),
    .div_i   (div_i),
    .corr_i  (corr_i),
    .div_q_o (div_q),
    .frac_q_o(frac_q),
    .bad_o   (bad)
  );

  baud_frac_acc acc_i (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .clear_i  (halt),
    .step_i   (wrap),
    .frac_i   (frac_q),
    .stretch_o(stretch)
  );

  baud_period_cnt #(
    .DIV_W(DIV_W)
  ) cnt_i (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .clear_i  (halt),
    .div_i    (div_q),
    .stretch_i(stretch),
    .wrap_o   (wrap)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      tick_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      tick_o <= wrap;
      err_o  <= en_i && bad;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> (!tick_o && !err_o)); // R2
  AST_ERR_BLOCKS_TICK: assert property (@(posedge clk_i) disable iff (rst_i)
    err_o |-> !tick_o); // R9
endmodule

// File: tb/baud_tick_gen_tb_top.sv
module baud_tick_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en_u = 1'b0, en_r = 1'b0;
  logic [11:0] div_u = '0;
  logic [3:0]  div_r = '0;
  logic [7:0]  corr_u = '0, corr_r = '0;
  logic        tick_u, err_u, tick_r, err_r;
  int          cyc = 0;
  int          n_chk = 0;
  int          n_fail = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  baud_tick_gen #(.DIV_W(12), .ZERO_IS_ILLEGAL(1'b0)) dut_i (
    .clk_i(clk), .rst_i(rst), .en_i(en_u), .div_i(div_u), .corr_i(corr_u),
    .tick_o(tick_u), .err_o(err_u));

  baud_tick_gen #(.DIV_W(4), .ZERO_IS_ILLEGAL(1'b1)) dut_ir_i (
    .clk_i(clk), .rst_i(rst), .en_i(en_r), .div_i(div_r), .corr_i(corr_r),
    .tick_o(tick_r), .err_o(err_r));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic tick_of(input bit sel);
    return sel ? tick_r : tick_u;
  endfunction

  task automatic wait_tick(input bit sel, input string req, output int t);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick_of(sel) && n < 400);
    if (!tick_of(sel)) check(1'b0, req, 0, 1);
    t = cyc;
  endtask

  task automatic drive(input bit sel, input bit en, input int n, input logic [7:0] corr);
    if (sel) begin en_r = en; div_r = n[3:0]; corr_r = corr; end
    else begin en_u = en; div_u = n[11:0]; corr_u = corr; end
  endtask

  // model: each period uses (cur_n, cur_f); at its closing tick the
  // accumulator adds cur_f and the port values are captured
  task automatic run_case(input bit sel, input int n, input logic [7:0] corr, input int nt,
                          input int idle, input int chg_at, input int n2,
                          input logic [7:0] corr2, input string req);
    int t, prev, t_first, c, acc, cur_n, cur_f, in_n, in_f, sum;
    drive(sel, 1'b0, n, corr);
    for (int i = 0; i < idle; i++) begin
      @(negedge clk);
      check(!tick_of(sel) && !(sel ? err_r : err_u), "R2 idle quiet", int'(tick_of(sel)), 0);
    end
    drive(sel, 1'b1, n, corr);
    prev = cyc; t_first = 0;
    c = 0; acc = 0; cur_n = n; cur_f = int'(corr[7:4]); in_n = n; in_f = cur_f;
    for (int k = 0; k < nt; k++) begin
      wait_tick(sel, req, t);
      check(t - prev == cur_n + 1 + c, (k == 0) ? "R3 first tick" : req, t - prev, cur_n + 1 + c);
      sum = acc + cur_f; c = sum / 16; acc = sum % 16;
      cur_n = in_n; cur_f = in_f;
      if (k == 0) t_first = t;
      if (k == 16 && chg_at < 0)
        check(t - t_first == 16 * (n + 1) + int'(corr[7:4]), "R5 sixteen-period span",
              t - t_first, 16 * (n + 1) + int'(corr[7:4]));
      if (k == chg_at) begin
        drive(sel, 1'b1, n2, corr2);
        in_n = n2; in_f = int'(corr2[7:4]);
      end
      prev = t;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int t0, t;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!tick_u && !err_u && !tick_r && !err_r, "R1 reset state",
          int'({tick_u, err_u, tick_r, err_r}), 0);

    run_case(0, 4, 8'h00, 6, 2, -1, 0, 8'h00, "R6 integer period");
    run_case(0, 0, 8'h00, 5, 2, -1, 0, 8'h00, "R10 divisor zero");
    run_case(0, 0, 8'h80, 8, 2, -1, 0, 8'h00, "R10 divisor zero with carry");
    run_case(0, 7, 8'hF0, 18, 2, -1, 0, 8'h00, "R4 max fraction");
    run_case(0, 3, 8'h5F, 18, 2, -1, 0, 8'h00, "R8 low nibble ignored");
    run_case(0, 5, 8'h30, 6, 2, 1, 9, 8'hB0, "R7 reprogram at boundary");
    run_case(0, 6, 8'hA0, 3, 1, -1, 0, 8'h00, "R2 restart");
    run_case(0, 6, 8'hA0, 3, 1, -1, 0, 8'h00, "R2 restart");

    // zero-illegal variant
    drive(1, 1'b0, 0, 8'h40);
    repeat (2) @(negedge clk);
    drive(1, 1'b1, 0, 8'h40);
    repeat (3) @(negedge clk);
    check(err_r, "R9 error on zero", int'(err_r), 1);
    begin
      int seen = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (tick_r) seen++;
      end
      check(seen == 0 && err_r, "R9 no ticks on zero", seen, 0);
    end
    drive(1, 1'b1, 3, 8'h40);
    t0 = cyc;
    @(negedge clk);
    check(err_r, "R9 error held one edge", int'(err_r), 1);
    @(negedge clk);
    check(!err_r, "R9 error clears", int'(err_r), 0);
    wait_tick(1, "R9 resume", t);
    check(t - t0 == 5, "R9 resume first tick", t - t0, 5);
    run_case(1, 15, 8'h90, 18, 2, -1, 0, 8'h00, "R4 narrow variant");

    for (int i = 0; i < 8; i++) begin
      int rn;
      logic [7:0] rc;
      rn = 1 + int'($urandom % 20);
      rc = 8'($urandom);
      run_case(0, rn, rc, 18, 2, -1, 0, 8'h00, "R4 random");
    end

    drive(0, 1'b0, 0, 8'h00);
    drive(1, 1'b0, 1, 8'h00);
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule